// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave-side command decoder of a serial NOR flash. The chip-select, serial clock and serial data pins come in already synchronised to the system clock. SPI mode 0 is used, one data line only. The block oversamples these pins on the system clock and shifts in an opcode byte. Address, dummy and payload bytes follow, depending on the opcode. The block then issues single-cycle execute strobes to the memory-array controller. Each strobe carries a command kind, a 24-bit address and a payload byte.

Read and status commands fire as soon as their last header bit arrives, so the host may end them on any bit. Program, erase and status-write commands are judged only when chip select returns high. They need a whole number of bytes at that moment. A program or erase is also refused if its target region touches the range that the protection inputs describe.

Array busy is looked at on the clock that completes the opcode. If busy is high then, every opcode except status read is dropped for the rest of that select period.

The controller has six states:
- S_IDLE: chip select is high.
- S_OPCODE: collecting the first byte.
- S_ADDR: collecting three address bytes.
- S_DUMMY: one don't-care byte for fast read.
- S_DATA: the header is complete and payload is collected.
- S_DROP: the rest of the select period is discarded.

The transitions are:
- Chip-select fall: any state to S_OPCODE.
- Chip-select rise: any state to S_IDLE.
- Opcode done: S_OPCODE to S_ADDR, S_DATA or S_DROP.
- Address done: S_ADDR to S_DUMMY or S_DATA.
- Dummy done: S_DUMMY to S_DATA.

Top module: `spi_flash_cmd_frontend`

## Requirements
- R1: After reset exec_valid is low. Every strobe lasts exactly one clock cycle.
- R2: A chip-select fall restarts the bit count. Serial data is sampled on each rising serial clock while select is low, most significant bit first. The first byte is the opcode and the address is the next three bytes, high byte first.
- R3: Opcode 0x03 gives kind 1 (read) with the 24-bit address. The strobe comes on the clock after the 32nd bit is sampled, and ending the command on any later bit does not cancel it. A read ended before bit 32 gives no strobe.
- R4: Opcode 0x0B gives kind 1 with the address after one further dummy byte, that is on the clock after bit 40.
- R5: Opcode 0x05 gives kind 2 with address 0 on the clock after bit 8, whether or not busy is high.
- R6: If busy is high on the clock where the eighth opcode bit is sampled, no strobe comes from that command unless the opcode is 0x05.
- R7: Opcodes 0x02, 0x20, 0xD8, 0xC7 and 0x01 strobe only on the clock after chip select rises, and only if the bit count at that moment is a multiple of 8.
- R8: Opcode 0x02 gives kind 3 (program) with the address, and exec_data holds the first payload byte. It needs at least one payload byte and targets the 256-byte page of the address.
- R9: Opcode 0x20 gives kind 4 and erases the 4 KiB sector of the address. Opcode 0xD8 gives kind 5 and erases the 64 KiB block. Both need the full address. Opcode 0xC7 gives kind 6 with address 0 and needs nothing beyond the opcode.
- R10: Opcode 0x01 gives kind 7 (status write) with address 0, and exec_data holds the byte that follows the opcode.
- R11: The protected range is set by bp, tb and sec:
  - bp = 0 protects nothing.
  - With sec = 0 the size is 64 KiB shifted left by bp-1, and bp of 5 or more covers the whole 1 MiB.
  - With sec = 1 the size is 4 KiB shifted left by bp-1, and bp of 5 or more gives 32 KiB.
  - tb = 0 places the range at the top of the array and tb = 1 at the bottom.
  - Only the low 20 address bits are compared.
- R12: A program or sector/block erase whose region overlaps the protected range gives no strobe. A chip erase gives no strobe when bp is nonzero.
- R13: Unknown opcodes, and write-class commands missing required bytes, give no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronised |
| sck | input | 1 | Serial clock, synchronised |
| mosi | input | 1 | Serial data in |
| busy | input | 1 | Array program/erase/status write in progress |
| prot_bp | input | 3 | Protection size field |
| prot_tb | input | 1 | Protection at bottom (1) or top (0) |
| prot_sec | input | 1 | Protection granularity 4 KiB (1) or 64 KiB (0) |
| exec_valid | output | 1 | Execute strobe |
| exec_kind | output | 3 | Command kind for the strobe |
| exec_addr | output | 24 | Target address |
| exec_data | output | 8 | First payload byte |

## Verification
The busy gate and the opcode decode can act on the same clock. The bench provokes this by raising busy exactly at the eighth opcode bit. It then checks that a read gives no strobe while a status read still gives one. It also raises busy one bit later and checks that the read then goes through. The bench reference model predicts, on every clock, whether a strobe is due and what it carries. Its predictions come from bit counts and interval arithmetic written independently of the RTL.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    typedef enum logic [2:0] {
        K_NONE       = 3'd0,
        K_READ       = 3'd1,
        K_STATUS     = 3'd2,
        K_PROGRAM    = 3'd3,
        K_SECT_ERASE = 3'd4,
        K_BLK_ERASE  = 3'd5,
        K_CHIP_ERASE = 3'd6,
        K_WR_STATUS  = 3'd7
    } exec_kind_t;

    typedef enum logic [2:0] {
        S_IDLE, S_OPCODE, S_ADDR, S_DUMMY, S_DATA, S_DROP
    } fe_state_t;

    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_FREAD  = 8'h0B;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_SERASE = 8'h20;
    localparam logic [7:0] OP_BERASE = 8'hD8;
    localparam logic [7:0] OP_CERASE = 8'hC7;
    localparam logic [7:0] OP_WRSR   = 8'h01;
endpackage

// File: rtl/sfc_shifter.sv
module sfc_shifter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             mosi,
    output logic             cs_fall,
    output logic             cs_rise,
    output logic             byte_done,
    output logic [7:0]       byte_val,
    output logic [CNT_W-4:0] byte_idx,
    output logic             aligned
);
    logic             cs_q;
    logic             sck_q;
    logic [6:0]       sr;
    logic [CNT_W-1:0] bitcnt;
    logic             sck_rise;
    logic             sat;

    assign cs_fall   = cs_q & ~cs_n;
    assign cs_rise   = ~cs_q & cs_n;
    assign sck_rise  = sck & ~sck_q & ~cs_n;
    assign sat       = (bitcnt == {CNT_W{1'b1}});
    assign byte_done = sck_rise && (bitcnt[2:0] == 3'd7) && !sat;
    assign byte_val  = {sr, mosi};
    assign byte_idx  = bitcnt[CNT_W-1:3];
    assign aligned   = (bitcnt[2:0] == 3'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sck_q  <= 1'b0;
            sr     <= '0;
            bitcnt <= '0;
        end else begin
            cs_q  <= cs_n;
            sck_q <= sck;
            if (cs_fall) begin
                bitcnt <= '0;
            end else if (sck_rise) begin
                sr <= {sr[5:0], mosi};
                if (!sat) bitcnt <= bitcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sfc_prot.sv
module sfc_prot #(
    parameter int MEM_AW = 20,
    parameter int BLK_AW = 16,
    parameter int SEC_AW = 12
) (
    input  logic [2:0]        bp,
    input  logic              tb,
    input  logic              sec,
    output logic              none,
    output logic [MEM_AW-1:0] lo,
    output logic [MEM_AW-1:0] hi
);
    localparam logic [MEM_AW:0] FULL = (MEM_AW+1)'(1) << MEM_AW;

    int              shamt;
    logic [MEM_AW:0] size;
    logic [MEM_AW:0] lo_w;
    logic [MEM_AW:0] hi_w;

    always_comb begin
        none = (bp == 3'd0);
        if (sec) shamt = (bp >= 3'd5) ? SEC_AW + 3 : SEC_AW + int'(bp) - 1;
        else     shamt = BLK_AW + int'(bp) - 1;
        if (shamt > MEM_AW || (!sec && bp >= 3'd6)) shamt = MEM_AW;
        if (none) shamt = 0;
        size = (MEM_AW+1)'(1) << shamt;
        if (tb) begin
            lo_w = '0;
            hi_w = size - 1'b1;
        end else begin
            lo_w = FULL - size;
            hi_w = FULL - 1'b1;
        end
        lo = lo_w[MEM_AW-1:0];
        hi = hi_w[MEM_AW-1:0];
    end
endmodule

// File: rtl/spi_flash_cmd_frontend.sv
module spi_flash_cmd_frontend
    import sfc_pkg::*;
#(
    parameter int MEM_AW  = 20,
    parameter int CNT_W   = 12,
    parameter int PAGE_AW = 8,
    parameter int SEC_AW  = 12,
    parameter int BLK_AW  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        sck,
    input  logic        mosi,
    input  logic        busy,
    input  logic [2:0]  prot_bp,
    input  logic        prot_tb,
    input  logic        prot_sec,
    output logic        exec_valid,
    output logic [2:0]  exec_kind,
    output logic [23:0] exec_addr,
    output logic [7:0]  exec_data
);
    logic             cs_fall, cs_rise, byte_done, aligned;
    logic [7:0]       byte_val;
    logic [CNT_W-4:0] byte_idx;

    sfc_shifter #(.CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .byte_done(byte_done),
        .byte_val(byte_val), .byte_idx(byte_idx), .aligned(aligned)
    );

    logic              p_none;
    logic [MEM_AW-1:0] p_lo, p_hi;

    sfc_prot #(.MEM_AW(MEM_AW), .BLK_AW(BLK_AW), .SEC_AW(SEC_AW)) u_prot (
        .bp(prot_bp), .tb(prot_tb), .sec(prot_sec),
        .none(p_none), .lo(p_lo), .hi(p_hi)
    );

    fe_state_t  state, nxt;
    logic [7:0] op_q, data_q;
    logic [23:0] addr_q, addr_full;
    logic       data_got;

    assign addr_full = {addr_q[15:0], byte_val};

    // target region of a program or erase, and its overlap with protection
    int                span;
    logic [MEM_AW-1:0] rmask, rs, re;
    logic              prot_hit;

    always_comb begin
        if (op_q == OP_PROG)        span = PAGE_AW;
        else if (op_q == OP_SERASE) span = SEC_AW;
        else                        span = BLK_AW;
        rmask    = (MEM_AW'(1) << span) - 1'b1;
        rs       = addr_q[MEM_AW-1:0] & ~rmask;
        re       = rs | rmask;
        prot_hit = !p_none && (rs <= p_hi) && (re >= p_lo);
    end

    // write-class acceptance at chip-select rise
    logic       wr_ok;
    exec_kind_t wr_kind;

    always_comb begin
        wr_ok   = 1'b0;
        wr_kind = K_NONE;
        if (state == S_DATA && aligned) begin
            case (op_q)
                OP_PROG:   begin wr_kind = K_PROGRAM;    wr_ok = data_got && !prot_hit; end
                OP_SERASE: begin wr_kind = K_SECT_ERASE; wr_ok = !prot_hit; end
                OP_BERASE: begin wr_kind = K_BLK_ERASE;  wr_ok = !prot_hit; end
                OP_CERASE: begin wr_kind = K_CHIP_ERASE; wr_ok = p_none; end
                OP_WRSR:   begin wr_kind = K_WR_STATUS;  wr_ok = data_got; end
                default:   ;
            endcase
        end
    end

    logic       fire;
    exec_kind_t fkind;
    logic [23:0] faddr;
    logic [7:0] fdata;

    always_comb begin
        nxt   = state;
        fire  = 1'b0;
        fkind = K_NONE;
        faddr = '0;
        fdata = '0;
        if (cs_rise) begin
            nxt = S_IDLE;
            if (wr_ok) begin
                fire  = 1'b1;
                fkind = wr_kind;
                if (wr_kind inside {K_PROGRAM, K_SECT_ERASE, K_BLK_ERASE}) faddr = addr_q;
                if (wr_kind inside {K_PROGRAM, K_WR_STATUS}) fdata = data_q;
            end
        end else if (cs_fall) begin
            nxt = S_OPCODE;
        end else if (byte_done) begin
            unique case (state)
                S_OPCODE: begin
                    if (busy && byte_val != OP_RDSR) begin
                        nxt = S_DROP;
                    end else begin
                        case (byte_val)
                            OP_RDSR: begin nxt = S_DROP; fire = 1'b1; fkind = K_STATUS; end
                            OP_READ, OP_FREAD, OP_PROG, OP_SERASE, OP_BERASE: nxt = S_ADDR;
                            OP_CERASE, OP_WRSR: nxt = S_DATA;
                            default: nxt = S_DROP;
                        endcase
                    end
                end
                S_ADDR: begin
                    if (byte_idx == (CNT_W-3)'(3)) begin
                        if (op_q == OP_FREAD) begin
                            nxt = S_DUMMY;
                        end else begin
                            nxt = S_DATA;
                            if (op_q == OP_READ) begin
                                fire = 1'b1; fkind = K_READ; faddr = addr_full;
                            end
                        end
                    end
                end
                S_DUMMY: begin
                    nxt = S_DATA; fire = 1'b1; fkind = K_READ; faddr = addr_q;
                end
                S_IDLE, S_DATA, S_DROP: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= '0;
            addr_q     <= '0;
            data_q     <= '0;
            data_got   <= 1'b0;
            exec_valid <= 1'b0;
            exec_kind  <= K_NONE;
            exec_addr  <= '0;
            exec_data  <= '0;
        end else begin
            exec_valid <= fire;
            if (fire) begin
                exec_kind <= fkind;
                exec_addr <= faddr;
                exec_data <= fdata;
            end
            if (cs_fall) begin
                op_q     <= '0;
                addr_q   <= '0;
                data_got <= 1'b0;
            end else if (byte_done) begin
                case (state)
                    S_OPCODE: op_q   <= byte_val;
                    S_ADDR:   addr_q <= addr_full;
                    S_DATA: if (!data_got) begin
                        data_q   <= byte_val;
                        data_got <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sfc_frontend_chk.sv
module sfc_frontend_chk
    import sfc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic [2:0] prot_bp,
    input logic       exec_valid,
    input logic [2:0] exec_kind
);
    // R1
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |=> !exec_valid);

    // R7
    wr_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_kind >= 3'(K_PROGRAM)) |-> ($past(cs_n) && !$past(cs_n, 2)));

    // R3
    read_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_kind == 3'(K_READ)) |-> !$past(cs_n));

    // R12
    chip_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_kind == 3'(K_CHIP_ERASE)) |-> ($past(prot_bp) == 3'd0));

    // R13
    kind_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> (exec_kind != 3'(K_NONE)));
endmodule

bind spi_flash_cmd_frontend sfc_frontend_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .prot_bp(prot_bp),
    .exec_valid(exec_valid), .exec_kind(exec_kind)
);

// File: tb/spi_flash_cmd_frontend_bench.sv
module spi_flash_cmd_frontend_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, busy = 1'b0;
    logic [2:0]  pbp = 3'd0;
    logic        ptb = 1'b0, psec = 1'b0;
    logic        exec_valid;
    logic [2:0]  exec_kind;
    logic [23:0] exec_addr;
    logic [7:0]  exec_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_flash_cmd_frontend u_spi_flash_cmd_frontend (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .busy(busy), .prot_bp(pbp), .prot_tb(ptb), .prot_sec(psec),
        .exec_valid(exec_valid), .exec_kind(exec_kind),
        .exec_addr(exec_addr), .exec_data(exec_data)
    );

    task automatic step(input logic c, input logic s, input logic m,
                        input logic ev, input logic [2:0] k,
                        input logic [23:0] a, input logic [7:0] d, input string req);
        cs_n = c; sck = s; mosi = m;
        @(negedge clk);
        checks++;
        if (exec_valid !== ev) begin
            errors++;
            $display("FAIL %s strobe actual=%b expected=%b", req, exec_valid, ev);
        end else if (ev && (exec_kind !== k || exec_addr !== a || exec_data !== d)) begin
            errors++;
            $display("FAIL %s payload actual=%0d/%h/%h expected=%0d/%h/%h",
                     req, exec_kind, exec_addr, exec_data, k, a, d);
        end
    endtask

    function automatic bit overlaps(int a, int span);
        int size, lo, hi, rs, re;
        if (pbp == 0) return 0;
        if (psec) size = (pbp >= 5) ? 32768 : (4096 << (pbp - 1));
        else      size = (pbp >= 5) ? (1 << 20) : (65536 << (pbp - 1));
        if (ptb) begin lo = 0; hi = size - 1; end
        else begin lo = (1 << 20) - size; hi = (1 << 20) - 1; end
        rs = (a % (1 << 20)) / span * span;
        re = rs + span - 1;
        return (rs <= hi) && (re >= lo);
    endfunction

    // word is left-aligned: bit i sent is word[63-i]
    task automatic run_cmd(input logic [63:0] word, input int nbits,
                           input int busy_at, input string req);
        logic [7:0]  op   = word[63:56];
        logic [23:0] addr = word[55:32];
        bit          bhit = (busy_at <= 7);
        int          nby  = nbits / 8;
        bit          wev  = 0;
        logic [2:0]  wk   = 0;
        logic [23:0] wa   = 0;
        logic [7:0]  wd   = 0;
        step(1, 0, 0, 0, 0, 0, 0, req);
        step(0, 0, 0, 0, 0, 0, 0, req);
        for (int i = 0; i < nbits; i++) begin
            bit          ev = 0;
            logic [2:0]  k  = 0;
            logic [23:0] a  = 0;
            int          nb = i + 1;
            if (i == busy_at) busy = 1'b1;
            step(0, 0, word[63-i], 0, 0, 0, 0, req);
            if (nb == 8 && op == 8'h05) begin ev = 1; k = 2; end
            if (!bhit && nb == 32 && op == 8'h03) begin ev = 1; k = 1; a = addr; end
            if (!bhit && nb == 40 && op == 8'h0B) begin ev = 1; k = 1; a = addr; end
            step(0, 1, word[63-i], ev, k, a, 0, req);
        end
        if (!bhit && nbits % 8 == 0) begin
            case (op)
                8'h02: if (nby >= 5 && !overlaps(int'(addr), 256)) begin
                    wev = 1; wk = 3; wa = addr; wd = word[31:24]; end
                8'h20: if (nby >= 4 && !overlaps(int'(addr), 4096)) begin
                    wev = 1; wk = 4; wa = addr; end
                8'hD8: if (nby >= 4 && !overlaps(int'(addr), 65536)) begin
                    wev = 1; wk = 5; wa = addr; end
                8'hC7: if (nby >= 1 && pbp == 0) begin wev = 1; wk = 6; end
                8'h01: if (nby >= 2) begin wev = 1; wk = 7; wd = word[55:48]; end
                default: ;
            endcase
        end
        step(1, 0, 0, wev, wk, wa, wd, req);
        busy = 1'b0;
        step(1, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        step(1, 0, 0, 0, 0, 0, 0, "R1");
        rst_n = 1'b1;
        step(1, 0, 0, 0, 0, 0, 0, "R1");

        // R2 R3 read, ended mid-byte after the address
        run_cmd({8'h03, 24'h012345, 32'hFF00_0000}, 34, 99, "R3");
        run_cmd({8'h03, 24'hC3A55A, 32'h0}, 32, 99, "R2");
        run_cmd({8'h03, 24'h012345, 32'h0}, 20, 99, "R3");
        // R4 fast read
        run_cmd({8'h0B, 24'hABCDEF, 8'h00, 24'h550000}, 45, 99, "R4");
        // R5 status read, idle and busy, truncated
        run_cmd({8'h05, 56'h0}, 8, 99, "R5");
        run_cmd({8'h05, 56'h0}, 13, 0, "R5");
        // R6 busy gating, including busy rising on the eighth opcode bit
        run_cmd({8'h03, 24'h000010, 32'h0}, 36, 0, "R6");
        run_cmd({8'h03, 24'h000020, 32'h0}, 36, 7, "R6");
        run_cmd({8'h05, 56'h0}, 8, 7, "R6");
        run_cmd({8'h03, 24'h000030, 32'h0}, 36, 8, "R6");
        run_cmd({8'h02, 24'h000100, 8'hA5, 24'h0}, 40, 0, "R6");
        run_cmd({8'h01, 8'h1C, 48'h0}, 16, 3, "R6");
        // R8 program
        run_cmd({8'h02, 24'h000100, 8'hA5, 24'h0}, 40, 99, "R8");
        run_cmd({8'h02, 24'h0ABC00, 8'h3C, 8'h99, 16'h0}, 48, 99, "R8");
        // R7 truncated writes
        run_cmd({8'h02, 24'h000100, 8'hA5, 24'h0}, 45, 99, "R7");
        run_cmd({8'h20, 24'h030000, 32'h0}, 31, 99, "R7");
        run_cmd({8'h01, 8'h1C, 48'h0}, 12, 99, "R7");
        run_cmd({8'hC7, 56'h0}, 9, 99, "R7");
        // R13 missing bytes and unknown opcode
        run_cmd({8'h02, 24'h000100, 32'h0}, 32, 99, "R13");
        run_cmd({8'h9F, 56'h0}, 32, 99, "R13");
        run_cmd({8'hD8, 24'h010000, 32'h0}, 24, 99, "R13");
        // R9 R10 erases and status write, unprotected
        run_cmd({8'h20, 24'h0F1234, 32'h0}, 32, 99, "R9");
        run_cmd({8'hD8, 24'h0F0000, 32'h0}, 32, 99, "R9");
        run_cmd({8'hC7, 56'h0}, 8, 99, "R9");
        run_cmd({8'h01, 8'h1C, 48'h0}, 16, 99, "R10");
        // R11 R12 top 64 KiB protected
        pbp = 3'd1; ptb = 1'b0; psec = 1'b0;
        run_cmd({8'h20, 24'h0F0000, 32'h0}, 32, 99, "R12");
        run_cmd({8'h20, 24'h0E0000, 32'h0}, 32, 99, "R11");
        run_cmd({8'hC7, 56'h0}, 8, 99, "R12");
        // bottom 8 KiB protected
        pbp = 3'd2; ptb = 1'b1; psec = 1'b1;
        run_cmd({8'hD8, 24'h000000, 32'h0}, 32, 99, "R12");
        run_cmd({8'hD8, 24'h010000, 32'h0}, 32, 99, "R11");
        run_cmd({8'h20, 24'h001000, 32'h0}, 32, 99, "R12");
        run_cmd({8'h20, 24'h002000, 32'h0}, 32, 99, "R11");
        // top 32 KiB via the saturating field value
        pbp = 3'd7; ptb = 1'b0; psec = 1'b1;
        run_cmd({8'h02, 24'h0FF000, 8'h11, 24'h0}, 40, 99, "R12");
        run_cmd({8'h02, 24'h0F7F00, 8'h22, 24'h0}, 40, 99, "R11");
        // whole array with block granularity
        pbp = 3'd6; ptb = 1'b1; psec = 1'b0;
        run_cmd({8'h20, 24'h050000, 32'h0}, 32, 99, "R12");
        pbp = 3'd3; ptb = 1'b1; psec = 1'b0;
        run_cmd({8'hD8, 24'h030000, 32'h0}, 32, 99, "R12");
        run_cmd({8'hD8, 24'h040000, 32'h0}, 32, 99, "R11");
        finish_run();
    end
endmodule